// File: doc/BRIEF.md
# Three-Wire Transition Symbol Encoder

This block turns a stream of 16-bit words into a clock-embedded pattern on three wires. No bit is ever sent directly. Each word is read as an unsigned number in base five and sent as seven digits, most significant digit first. Each digit is a transition symbol that moves the wires from their present state to one of five other states. The receiver gets its timing from the fact that the wires change on every symbol.

The wires always rest in one of six states. A state names a wire pair, called an axis (x, y or z), and a sign. The block drives the A, B and C wires to high, middle or low levels from that state. A producer hands words over on a valid/ready handshake. The block takes a new word only while it sends the last symbol of the word before, or while it is idle. Words that are sent back to back therefore give a continuous run of symbols, one per clock.

Top module: `tw_symbol_encoder`

## Requirements
- R1: A word is taken on a rising clock edge where in_valid and in_ready are both high. in_ready is high while the block is idle and during the cycle in which the seventh symbol is sent. For the six cycles after an accept, in_ready is low.
- R2: Each accepted word gives exactly seven state updates, one per clock, starting at the edge after the accept. They send the base-five digits of the word, most significant digit first.
- R3: A digit d (0 to 4) is sent as the 3-bit symbol {flip, rot, pol} whose value equals d. Only codes 000 to 100 ever occur.
- R4: Symbol 100 (flip) keeps the axis and inverts the sign.
- R5: When flip is 0, rot=0 steps the axis x to y, y to z and z to x, and rot=1 steps it the other way. pol=1 inverts the sign, and pol=0 keeps it.
- R6: wstate is {neg, axis[1:0]}, with x=00, y=01 and z=10. Axis code 11 never appears.
- R7: Every symbol changes wstate. sym_fire is high in exactly the cycles that follow a state update.
- R8: Wire level codes are low=0, mid=1 and high=2. Axis x drives A high and B low. Axis y drives B high and C low. Axis z drives C high and A low. The third wire is mid. A negative sign swaps the high wire and the low wire.
- R9: After reset, wstate is +x (000), in_ready is 1 and sym_fire is 0.
- R10: While no word is in flight, wstate holds and sym_fire stays 0.
- R11: A word offered while in_ready is low is ignored. It never reaches the wires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered |
| in_word | input | 16 | Word to encode |
| in_ready | output | 1 | Block can take a word at this edge |
| sym_fire | output | 1 | The wire state was updated at the last edge |
| wstate | output | 3 | Current wire state {neg, axis} |
| wire_a | output | 2 | Level code of wire A |
| wire_b | output | 2 | Level code of wire B |
| wire_c | output | 2 | Level code of wire C |

## Verification
The bench recovers each symbol from consecutive wire states and rebuilds the words. Any fault in the transition rule, the digit order or the base-five split therefore shows as a wrong word within seven cycles of its accept. A digit counter that slips shows at once as a word that arrives too early or too late, or as an in_ready pulse in the wrong cycle. A bad state register or level map shows on the very next symbol: as an unchanged or illegal wstate, or as wire levels that do not match the state.

// File: rtl/tw_enc_pkg.sv
package tw_enc_pkg;

  localparam logic [1:0] AX_X = 2'd0;
  localparam logic [1:0] AX_Y = 2'd1;
  localparam logic [1:0] AX_Z = 2'd2;

  localparam logic [1:0] LV_LOW  = 2'd0;
  localparam logic [1:0] LV_MID  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;

  localparam logic [2:0] SYM_FLIP = 3'b100;

  typedef struct packed {
    logic       neg;
    logic [1:0] axis;
  } wstate_t;

  // number of base-5 digits needed for a w-bit unsigned value
  function automatic int unsigned digits_for(int unsigned w);
    longint unsigned span;
    int unsigned n;
    span = 1;
    n = 0;
    while (span < (longint'(1) << w)) begin
      span = span * 5;
      n = n + 1;
    end
    return n;
  endfunction

  function automatic logic [1:0] axis_cw(logic [1:0] a);
    case (a)
      AX_X:    return AX_Y;
      AX_Y:    return AX_Z;
      default: return AX_X;
    endcase
  endfunction

  function automatic logic [1:0] axis_ccw(logic [1:0] a);
    case (a)
      AX_X:    return AX_Z;
      AX_Y:    return AX_X;
      default: return AX_Y;
    endcase
  endfunction

  // next wire state from symbol {flip, rot, pol}
  function automatic wstate_t step(wstate_t s, logic [2:0] sym);
    wstate_t n;
    if (sym[2]) begin
      n.axis = s.axis;
      n.neg  = ~s.neg;
    end else begin
      n.axis = sym[1] ? axis_ccw(s.axis) : axis_cw(s.axis);
      n.neg  = s.neg ^ sym[0];
    end
    return n;
  endfunction

  // level codes {a, b, c}
  function automatic logic [5:0] levels(wstate_t s);
    logic [1:0] hi, lo;
    logic [1:0] a, b, c;
    hi = s.neg ? LV_LOW  : LV_HIGH;
    lo = s.neg ? LV_HIGH : LV_LOW;
    case (s.axis)
      AX_X:    begin a = hi;     b = lo;     c = LV_MID; end
      AX_Y:    begin a = LV_MID; b = hi;     c = lo;     end
      default: begin a = lo;     b = LV_MID; c = hi;     end
    endcase
    return {a, b, c};
  endfunction

endpackage

// File: rtl/tw_digit_seq.sv
module tw_digit_seq #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_SYM  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              emit,
  output logic [2:0]        sym
);
  localparam int unsigned CNT_W = (N_SYM > 1) ? $clog2(N_SYM) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SYM - 1);

  typedef logic [N_SYM-1:0][2:0] dig_vec_t;

  // index 0 holds the most significant digit
  function automatic dig_vec_t to_base5(logic [WORD_W-1:0] w);
    dig_vec_t d;
    logic [WORD_W-1:0] v;
    v = w;
    for (int i = int'(N_SYM) - 1; i >= 0; i--) begin
      d[i] = 3'(v % WORD_W'(5));
      v    = v / WORD_W'(5);
    end
    return d;
  endfunction

  dig_vec_t         digs;
  logic             busy;
  logic [CNT_W-1:0] idx;
  logic             last_sym;
  logic             accept;

  assign last_sym = (idx == LAST_IDX);
  assign in_ready = !busy || last_sym;
  assign accept   = in_valid && in_ready;
  assign emit     = busy;
  assign sym      = digs[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      digs <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
      digs <= to_base5(in_word);
    end else if (busy && last_sym) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_legal_symbol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (sym <= 3'b100));

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |-> in_ready);

endmodule

// File: rtl/tw_wire_state.sv
module tw_wire_state
  import tw_enc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    emit,
  input  logic [2:0] sym,
  output wstate_t state,
  output logic    fire
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '{neg: 1'b0, axis: AX_X};
      fire  <= 1'b0;
    end else begin
      fire <= emit;
      if (emit) state <= step(state, sym);
    end
  end

  assert_legal_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state.axis != 2'b11);

  assert_state_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> state != $past(state));

  assert_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && sym == SYM_FLIP) |=> (state.axis == $past(state.axis)) && (state.neg != $past(state.neg)));

  assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !sym[2]) |=> (state.axis != $past(state.axis)) && (state.neg == ($past(state.neg) ^ $past(sym[0]))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(state) && !fire);

endmodule

// File: rtl/tw_level_map.sv
module tw_level_map
  import tw_enc_pkg::*;
(
  input  wstate_t    state,
  output logic [1:0] wire_a,
  output logic [1:0] wire_b,
  output logic [1:0] wire_c
);
  always_comb begin
    {wire_a, wire_b, wire_c} = levels(state);
  end
endmodule

// File: rtl/tw_symbol_encoder.sv
module tw_symbol_encoder
  import tw_enc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              sym_fire,
  output logic [2:0]        wstate,
  output logic [1:0]        wire_a,
  output logic [1:0]        wire_b,
  output logic [1:0]        wire_c
);
  localparam int unsigned N_SYM = digits_for(WORD_W);

  logic       emit;
  logic [2:0] sym;
  wstate_t    cur_state;

  tw_digit_seq #(.WORD_W(WORD_W), .N_SYM(N_SYM)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .in_ready (in_ready),
    .emit     (emit),
    .sym      (sym)
  );

  tw_wire_state state_i (
    .clk   (clk),
    .rst_n (rst_n),
    .emit  (emit),
    .sym   (sym),
    .state (cur_state),
    .fire  (sym_fire)
  );

  tw_level_map map_i (
    .state  (cur_state),
    .wire_a (wire_a),
    .wire_b (wire_b),
    .wire_c (wire_c)
  );

  assign wstate = cur_state;

  assert_levels_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_a != wire_b) && (wire_b != wire_c) && (wire_a != wire_c)
    && (wire_a != 2'd3) && (wire_b != 2'd3) && (wire_c != 2'd3));

endmodule

// File: tb/tw_symbol_encoder_tb.sv
module tw_symbol_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_ready, sym_fire;
  logic [2:0]  wstate;
  logic [1:0]  wire_a, wire_b, wire_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tw_symbol_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .sym_fire(sym_fire), .wstate(wstate),
    .wire_a(wire_a), .wire_b(wire_b), .wire_c(wire_c)
  );

  // word, expected leading base-5 digit
  localparam logic [18:0] VEC [8] = '{
    {16'h0000, 3'd0}, {16'hFFFF, 3'd4}, {16'h3D09, 3'd1}, {16'h7A12, 3'd2},
    {16'hB71B, 3'd3}, {16'h3D08, 3'd0}, {16'h1234, 3'd0}, {16'hA5A5, 3'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side decoder
  logic [15:0] exp_q[$];
  logic [2:0]  prev;
  int          dcount;
  int          acc;
  int          first_dig;
  int          last_first;

  function automatic logic [5:0] exp_levels(logic [2:0] s);
    logic [1:0] l [3];
    int ax;
    ax = int'(s[1:0]);
    l[ax]         = s[2] ? 2'd0 : 2'd2;
    l[(ax+1) % 3] = s[2] ? 2'd2 : 2'd0;
    l[(ax+2) % 3] = 2'd1;
    return {l[0], l[1], l[2]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      prev = 3'b000; dcount = 0; acc = 0;
    end else begin
      if (sym_fire) begin
        int d;
        chk(wstate != prev, "R7 state change", wstate, prev);
        chk(wstate[1:0] != 2'b11, "R6 legal state", wstate, 0);
        chk({wire_a, wire_b, wire_c} == exp_levels(wstate), "R8 levels",
            {wire_a, wire_b, wire_c}, exp_levels(wstate));
        if (wstate[1:0] == prev[1:0]) d = 4;
        else begin
          logic [1:0] cw;
          cw = (prev[1:0] == 2'd2) ? 2'd0 : prev[1:0] + 2'd1;
          d = ((wstate[1:0] == cw) ? 0 : 2) + int'(wstate[2] ^ prev[2]);
        end
        if (dcount == 0) first_dig = d;
        acc = acc * 5 + d;
        dcount++;
        if (dcount == 7) begin
          if (exp_q.size() == 0) chk(0, "R11 unexpected word", acc, -1);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(acc == int'(e), "R2 R3 R4 R5 word round trip", acc, e);
          end
          last_first = first_dig;
          dcount = 0; acc = 0;
        end
      end else begin
        chk(wstate == prev, "R10 idle hold", wstate, prev);
      end
      prev = wstate;
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_one(input logic [15:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_word = w; exp_q.push_back(w);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(wstate == 3'b000, "R9 reset state", wstate, 0);
    chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);
    chk(sym_fire == 1'b0, "R9 reset fire", sym_fire, 0);
    chk({wire_a, wire_b, wire_c} == {2'd2, 2'd0, 2'd1}, "R8 R9 reset levels",
        {wire_a, wire_b, wire_c}, {2'd2, 2'd0, 2'd1});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sym_fire == 1'b0 && wstate == 3'b000, "R10 idle after reset", wstate, 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      send_one(VEC[i][18:3]);
      drain();
      chk(last_first == int'(VEC[i][2:0]), "R2 leading digit", last_first, VEC[i][2:0]);
    end

    // R1 ready timing, with R11 junk held on the bus while busy
    @(negedge clk);
    in_valid = 1'b1; in_word = 16'h0F0F; exp_q.push_back(16'h0F0F);
    @(negedge clk);
    in_word = 16'hDEAD;
    for (int k = 0; k < 6; k++) begin
      chk(in_ready == 1'b0, "R1 ready low while busy", in_ready, 0);
      if (k < 5) @(negedge clk);
    end
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready on last symbol", in_ready, 1);
    in_valid = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R11 junk ignored", exp_q.size(), 0);

    // back-to-back random words
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] r;
      while (!in_ready) @(negedge clk);
      r = (i == 0) ? 16'hFFFF : ((i == 1) ? 16'h0000 : 16'($urandom));
      in_word = r; exp_q.push_back(r);
      @(negedge clk);
      if (i < 19) chk(sym_fire == 1'b1 || i == 0, "R2 continuous symbols", sym_fire, 1);
    end
    in_valid = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(sym_fire == 1'b0 && in_ready == 1'b1, "R10 idle after burst", sym_fire, 0);
    finish_run();
  end
endmodule